// File: doc/BRIEF.md
# Byte-Accessed 16-bit Compare Timer

This block is a 16-bit up-counter with two 16-bit compare channels, A and B. Software reaches it through an 8-bit register bus. The counter moves only on cycles where the `tick` input is high, so an external prescaler sets the count rate. Each tick, the counter value is compared against both compare registers. A match sets that channel's flag and runs that channel's configured waveform action, which is none, toggle, clear or set. In clear-on-A mode, a match on channel A returns the counter to zero. In normal mode, the counter rolls over from 0xFFFF to 0x0000 and raises an overflow flag.

All three 16-bit registers (the counter and the two compare values) share one 8-bit holding latch. This latch makes a 16-bit value move as one unit over the byte bus. Reading a low byte captures the matching high byte in the latch. Writing a high byte only fills the latch, and the following low-byte write commits both bytes together. A software write to the counter masks compare matches on the next tick. A force strobe runs a channel's waveform action at once, without touching its flag or the counter.

Register map (byte addresses): 0 counter low, 1 counter high, 2 compare A low, 3 compare A high, 4 compare B low, 5 compare B high, 6 control, 7 force, 8 flags, 9 interrupt enables. The control register holds: bit 0 mode (1 = clear on A); bits 2:1 action A; bits 4:3 action B. Action codes are 0 none, 1 toggle, 2 clear, 3 set. In the force register, bit 0 forces A and bit 1 forces B. In the flags and enables registers, bit 0 is match A, bit 1 is match B and bit 2 is overflow.

Top module: `tmr16_top`

## Requirements
- R1: After reset, every register reads zero and all waveform and interrupt outputs are low.
- R2: A high-byte write (address 1, 3 or 5) changes only the holding latch. The next low-byte write to the matching address (0, 2 or 4) loads {latch, data} as one 16-bit value.
- R3: Reading a low byte returns it combinationally and copies that register's high byte into the latch. A high-byte read returns the latch, even if the register has changed since.
- R4: The counter increments by one on each cycle with `tick` high, and holds its value otherwise.
- R5: In normal mode, a tick at 0xFFFF gives 0x0000 and sets flags bit 2.
- R6: In clear-on-A mode (control bit 0 = 1), a tick that matches channel A loads zero instead of incrementing.
- R7: A tick on which the counter equals a compare register sets that channel's flag (flags bit 0 or 1).
- R8: A match drives the channel's waveform output according to its action code: 0 none, 1 toggle, 2 clear, 3 set.
- R9: After a counter write, no compare channel matches on the next tick, even if the values are equal.
- R10: Writing a one to a flag bit clears it. Each interrupt output is its flag ANDed with its enable bit (address 9).
- R11: Writing a one to force bit 0 or 1 (address 7) runs that channel's action on the next clock. It leaves the flags unchanged and does not clear the counter.
- R12: The force register always reads zero. Control bits 7:5 read zero whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (low-byte reads load the latch) |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| irq_match_a | output | 1 | Channel A match interrupt |
| irq_match_b | output | 1 | Channel B match interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
Read data is combinational, so it is sampled 1 ns after the read strobe is applied in the same cycle. The latch capture caused by that read shows up only in a later high-byte read. Counter, flag and waveform effects of a tick, force or write are registered once and are due at the clock edge that samples the stimulus. The bench drives inputs on the falling edge and compares outputs against its model on every falling edge. The masked tick after a counter write is the first tick edge after the commit edge, so the bench places the equal-value tick exactly there and looks at flags and waveforms afterwards.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_TOGGLE = 2'd1,
      ACT_CLEAR  = 2'd2,
      ACT_SET    = 2'd3
   } wave_act_e;

   // byte addresses; the low/high pairing is decoded by the bus unit
   localparam int unsigned REG_CNT_LO  = 0;
   localparam int unsigned REG_CNT_HI  = 1;
   localparam int unsigned REG_CMP_LO0 = 2;  // channel i low byte at 2+2i
   localparam int unsigned REG_CTRL    = 6;
   localparam int unsigned REG_FORCE   = 7;
   localparam int unsigned REG_FLAGS   = 8;
   localparam int unsigned REG_ENABLE  = 9;

   localparam int unsigned NUM_CH  = 2;
   localparam int unsigned NUM_EVT = NUM_CH + 1;  // matches plus overflow

   function automatic logic wave_next(wave_act_e act, logic cur);
      case (act)
         ACT_TOGGLE: return ~cur;
         ACT_CLEAR:  return 1'b0;
         ACT_SET:    return 1'b1;
         default:    return cur;
      endcase
   endfunction

endpackage

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   input  logic          clr,
   output logic [CW-1:0] cnt,
   output logic          blk,
   output logic          wrap
);

   localparam logic [CW-1:0] CNT_MAX = '1;

   if (CW < 2) begin : g_cw_bad
      $error("tmr16_counter: CW must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         blk <= 1'b0;
      end else if (ld) begin
         cnt <= ld_val;
         blk <= 1'b1;
      end else if (tick) begin
         blk <= 1'b0;
         cnt <= clr ? '0 : cnt + CW'(1);
      end
   end

   assign wrap = tick && !ld && !clr && (cnt == CNT_MAX);

   // R4
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ld) |=> $stable(cnt));

   // R5
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));

   // R6
   ctc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld && clr) |=> (cnt == '0));

endmodule

// File: rtl/tmr16_channel.sv
module tmr16_channel
   import tmr16_pkg::*;
#(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          blk,
   input  logic          ld,
   input  logic [CW-1:0] cnt,
   input  logic          cmp_we,
   input  logic [CW-1:0] wval,
   input  wave_act_e     act,
   input  logic          frc,
   output logic [CW-1:0] cmp,
   output logic          hit,
   output logic          wave
);

   // a counter commit or a pending mask both suppress the compare
   assign hit = tick && !blk && !ld && (cnt == cmp);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp  <= '0;
         wave <= 1'b0;
      end else begin
         if (cmp_we) cmp <= wval;
         if (hit || frc) wave <= wave_next(act, wave);
      end
   end

   // R8
   act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit || frc) && act == ACT_SET) |=> wave);

   // R8
   act_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_NONE) |=> $stable(wave));

endmodule

// File: rtl/tmr16_busif.sv
module tmr16_busif
   import tmr16_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 4,
   localparam int unsigned CW = 2 * DW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               rd,
   input  logic [AW-1:0]      addr,
   input  logic [DW-1:0]      wdata,
   input  logic [CW-1:0]      cnt,
   input  logic [CW-1:0]      cmp_a,
   input  logic [CW-1:0]      cmp_b,
   input  logic [NUM_EVT-1:0] flags,
   output logic               cnt_we,
   output logic [NUM_CH-1:0]  cmp_we,
   output logic [CW-1:0]      wval,
   output logic               mode_ctc,
   output wave_act_e          act_a,
   output wave_act_e          act_b,
   output logic [NUM_CH-1:0]  frc,
   output logic [NUM_EVT-1:0] flag_clr,
   output logic [NUM_EVT-1:0] en,
   output logic [DW-1:0]      rdata
);

   localparam int unsigned CTRL_BITS = 1 + 2 * NUM_CH;

   if (DW < CTRL_BITS) begin : g_dw_bad
      $error("tmr16_busif: DW too narrow for the control fields");
   end
   if (AW < 4) begin : g_aw_bad
      $error("tmr16_busif: AW must reach address 9");
   end

   logic [DW-1:0] hold_q;
   logic          hi_wr;
   logic          lo_rd;
   logic [DW-1:0] hi_src;

   function automatic logic is_addr(logic [AW-1:0] a, int unsigned r);
      return a == AW'(r);
   endfunction

   assign cnt_we = wr && is_addr(addr, REG_CNT_LO);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      assign cmp_we[i] = wr && is_addr(addr, REG_CMP_LO0 + 2 * i);
      assign frc[i]    = wr && is_addr(addr, REG_FORCE) && wdata[i];
   end
   assign wval     = {hold_q, wdata};
   assign flag_clr = (wr && is_addr(addr, REG_FLAGS)) ? wdata[NUM_EVT-1:0] : '0;

   assign hi_wr = wr && (is_addr(addr, REG_CNT_HI) ||
                         is_addr(addr, REG_CMP_LO0 + 1) ||
                         is_addr(addr, REG_CMP_LO0 + 3));
   assign lo_rd = rd && (is_addr(addr, REG_CNT_LO) ||
                         is_addr(addr, REG_CMP_LO0) ||
                         is_addr(addr, REG_CMP_LO0 + 2));

   always_comb begin
      hi_src = cnt[CW-1:DW];
      if (is_addr(addr, REG_CMP_LO0))     hi_src = cmp_a[CW-1:DW];
      if (is_addr(addr, REG_CMP_LO0 + 2)) hi_src = cmp_b[CW-1:DW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q   <= '0;
         mode_ctc <= 1'b0;
         act_a    <= ACT_NONE;
         act_b    <= ACT_NONE;
         en       <= '0;
      end else begin
         if (hi_wr)      hold_q <= wdata;
         else if (lo_rd) hold_q <= hi_src;
         if (wr && is_addr(addr, REG_CTRL)) begin
            mode_ctc <= wdata[0];
            act_a    <= wave_act_e'(wdata[2:1]);
            act_b    <= wave_act_e'(wdata[4:3]);
         end
         if (wr && is_addr(addr, REG_ENABLE)) en <= wdata[NUM_EVT-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         AW'(REG_CNT_LO):      rdata = cnt[DW-1:0];
         AW'(REG_CMP_LO0):     rdata = cmp_a[DW-1:0];
         AW'(REG_CMP_LO0 + 2): rdata = cmp_b[DW-1:0];
         AW'(REG_CNT_HI),
         AW'(REG_CMP_LO0 + 1),
         AW'(REG_CMP_LO0 + 3): rdata = hold_q;
         AW'(REG_CTRL):        rdata = DW'({act_b, act_a, mode_ctc});
         AW'(REG_FLAGS):       rdata = DW'(flags);
         AW'(REG_ENABLE):      rdata = DW'(en);
         default:              rdata = '0;
      endcase
   end

   // R2
   hi_wr_only_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr |=> ($stable(cmp_a) && $stable(cmp_b)));

   // R12
   force_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && is_addr(addr, REG_FORCE)) |-> (rdata == '0));

endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
   import tmr16_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          wave_a,
   output logic          wave_b,
   output logic          irq_match_a,
   output logic          irq_match_b,
   output logic          irq_ovf
);

   localparam int unsigned CW = 2 * DW;

   logic [CW-1:0]      cnt;
   logic               blk;
   logic               wrap;
   logic               cnt_we;
   logic [NUM_CH-1:0]  cmp_we;
   logic [CW-1:0]      wval;
   logic               mode_ctc;
   wave_act_e          act_a;
   wave_act_e          act_b;
   logic [NUM_CH-1:0]  frc;
   logic [NUM_EVT-1:0] flag_clr;
   logic [NUM_EVT-1:0] en;
   logic [NUM_EVT-1:0] flags_q;
   logic [NUM_CH-1:0]  hit;
   logic [NUM_CH-1:0]  wave;
   logic [CW-1:0]      cmp_val [NUM_CH];
   wave_act_e          ch_act  [NUM_CH];

   assign ch_act[0] = act_a;
   assign ch_act[1] = act_b;

   tmr16_busif #(.DW(DW), .AW(AW)) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr),
      .rd       (bus_rd),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .cnt      (cnt),
      .cmp_a    (cmp_val[0]),
      .cmp_b    (cmp_val[1]),
      .flags    (flags_q),
      .cnt_we   (cnt_we),
      .cmp_we   (cmp_we),
      .wval     (wval),
      .mode_ctc (mode_ctc),
      .act_a    (act_a),
      .act_b    (act_b),
      .frc      (frc),
      .flag_clr (flag_clr),
      .en       (en),
      .rdata    (bus_rdata)
   );

   tmr16_counter #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .ld     (cnt_we),
      .ld_val (wval),
      .clr    (mode_ctc && hit[0]),
      .cnt    (cnt),
      .blk    (blk),
      .wrap   (wrap)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tmr16_channel #(.CW(CW)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .blk    (blk),
         .ld     (cnt_we),
         .cnt    (cnt),
         .cmp_we (cmp_we[i]),
         .wval   (wval),
         .act    (ch_act[i]),
         .frc    (frc[i]),
         .cmp    (cmp_val[i]),
         .hit    (hit[i]),
         .wave   (wave[i])
      );
   end

   // new events win over a same-cycle clear
   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~flag_clr) | {wrap, hit};
   end

   assign wave_a      = wave[0];
   assign wave_b      = wave[1];
   assign irq_match_a = flags_q[0] && en[0];
   assign irq_match_b = flags_q[1] && en[1];
   assign irq_ovf     = flags_q[2] && en[2];

   // R9
   ld_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we ##1 (tick && !cnt_we) |-> (hit == '0));

   // R11
   force_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((frc != '0) && !tick) |=> $stable(flags_q));

   // R10
   flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[2] && !wrap) |=> !flags_q[2]);

endmodule

// File: tb/sim_tmr16_top.sv
module sim_tmr16_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       wave_a, wave_b, irq_a, irq_b, irq_o;

   always #5 clk = ~clk;

   tmr16_top u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(wr), .bus_rd(rd),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
      .wave_a(wave_a), .wave_b(wave_b), .irq_match_a(irq_a),
      .irq_match_b(irq_b), .irq_ovf(irq_o)
   );

   int checks = 0;
   int errors = 0;
   bit live = 0;
   bit done = 0;

   // behavioural reference model
   int m_cnt, m_temp, m_blk, m_flags, m_en, m_mode, ovf, clra, ldc;
   int m_cmp [2];
   int m_act [2];
   int m_wave [2];
   int mh [2];
   int mf [2];

   function automatic int act_apply(int a, int w);
      if (a == 1) return w ^ 1;
      if (a == 2) return 0;
      if (a == 3) return 1;
      return w;
   endfunction

   function automatic int exp_read(int a);
      case (a)
         0: return m_cnt & 255;
         2: return m_cmp[0] & 255;
         4: return m_cmp[1] & 255;
         1, 3, 5: return m_temp;
         6: return m_mode | (m_act[0] << 1) | (m_act[1] << 3);
         8: return m_flags;
         9: return m_en;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_temp = 0; m_blk = 0; m_flags = 0; m_en = 0; m_mode = 0;
         for (int i = 0; i < 2; i++) begin
            m_cmp[i] = 0; m_act[i] = 0; m_wave[i] = 0;
         end
      end else begin
         ldc = (wr && addr == 0) ? 1 : 0;
         for (int i = 0; i < 2; i++) begin
            mh[i] = (tick && m_blk == 0 && ldc == 0 && m_cnt == m_cmp[i]) ? 1 : 0;
            mf[i] = (wr && addr == 7 && wdata[i]) ? 1 : 0;
            if (mh[i] != 0 || mf[i] != 0) m_wave[i] = act_apply(m_act[i], m_wave[i]);
         end
         clra = m_mode & mh[0];
         ovf  = (tick && ldc == 0 && clra == 0 && m_cnt == 65535) ? 1 : 0;
         if (rd) begin
            if (addr == 0) m_temp = m_cnt >> 8;
            if (addr == 2) m_temp = m_cmp[0] >> 8;
            if (addr == 4) m_temp = m_cmp[1] >> 8;
         end
         if (wr && addr == 8) m_flags = m_flags & ~int'(wdata);
         m_flags = (m_flags | mh[0] | (mh[1] << 1) | (ovf << 2)) & 7;
         if (ldc != 0) begin
            m_cnt = m_temp * 256 + int'(wdata);
            m_blk = 1;
         end else if (tick) begin
            m_blk = 0;
            m_cnt = (clra != 0) ? 0 : ((m_cnt + 1) & 65535);
         end
         if (wr) begin
            case (addr)
               1, 3, 5: m_temp = int'(wdata);
               2: m_cmp[0] = m_temp * 256 + int'(wdata);
               4: m_cmp[1] = m_temp * 256 + int'(wdata);
               6: begin
                  m_mode = wdata[0]; m_act[0] = wdata[2:1]; m_act[1] = wdata[4:3];
               end
               9: m_en = wdata & 8'h07;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(int act, int exp, string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // R8 R10: outputs against the model on every falling edge
   always @(negedge clk) begin
      if (live && !done) begin
         chk(wave_a, m_wave[0], "R8 wave_a");
         chk(wave_b, m_wave[1], "R8 wave_b");
         chk(irq_a, (m_flags & m_en) & 1, "R10 irq_a");
         chk(irq_b, ((m_flags & m_en) >> 1) & 1, "R10 irq_b");
         chk(irq_o, ((m_flags & m_en) >> 2) & 1, "R10 irq_ovf");
      end
   end

   task automatic bus_wr(int a, int d);
      @(negedge clk); wr = 1'b1; addr = 4'(a); wdata = 8'(d);
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_rd(int a, output int v, input string tag);
      @(negedge clk); rd = 1'b1; addr = 4'(a);
      #1;
      v = int'(rdata);
      chk(v, exp_read(a), tag);
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic pulse(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic wr16(int lo_addr, int val);
      bus_wr(lo_addr + 1, val >> 8);
      bus_wr(lo_addr, val & 255);
   endtask

   task automatic finish_run();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      int v, w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      live = 1;

      // R1 reset values
      for (int a = 0; a < 10; a++) begin
         bus_rd(a, v, "R1 model");
         chk(v, 0, "R1 reset read");
      end

      // R2 high byte alone does nothing, then atomic commit
      bus_wr(3, 8'h12);
      bus_rd(2, v, "R2 model");
      chk(v, 0, "R2 hi-only no effect");
      bus_wr(3, 8'h12);
      bus_wr(2, 8'h34);
      bus_rd(2, v, "R2 model");
      chk(v, 8'h34, "R2 low byte");
      bus_rd(3, v, "R2 model");
      chk(v, 8'h12, "R2 high byte");

      // R3 read latch holds high byte while counter runs
      wr16(0, 16'h00F0);
      tick = 1'b1;
      bus_rd(0, v, "R3 model");
      repeat (40) @(negedge clk);
      tick = 1'b0;
      bus_rd(1, v, "R3 model");
      chk(v, 8'h00, "R3 latched high");
      bus_rd(0, v, "R3 model");
      bus_rd(1, v, "R3 model");
      chk(v, 8'h01, "R3 fresh high");

      // R4 hold without tick, step with tick
      wr16(0, 16'h0100);
      repeat (5) @(negedge clk);
      bus_rd(0, v, "R4 model");
      chk(v, 8'h00, "R4 hold");
      pulse(3);
      bus_rd(0, v, "R4 model");
      chk(v, 8'h03, "R4 three ticks");

      // R5 wrap and overflow flag, R10 enable gating
      bus_wr(9, 7);
      wr16(0, 16'hFFFE);
      pulse(1);
      bus_rd(8, v, "R5 model");
      chk(v, 0, "R5 no flag before wrap");
      pulse(1);
      bus_rd(8, v, "R5 model");
      chk(v, 4, "R5 overflow flag");
      chk(irq_o, 1, "R10 irq_ovf enabled");
      bus_rd(0, v, "R5 model");
      chk(v, 0, "R5 wrapped count");
      bus_wr(8, 4);
      bus_rd(8, v, "R10 model");
      chk(v, 0, "R10 write-one clear");

      // R7 R8 matches with toggle on A and set on B
      bus_wr(6, 8'h1A);
      wr16(2, 5);
      wr16(4, 7);
      wr16(0, 3);
      pulse(5);
      bus_rd(8, v, "R7 model");
      chk(v, 3, "R7 both match flags");
      chk(wave_a, 1, "R8 toggle");
      chk(wave_b, 1, "R8 set");
      bus_wr(9, 0);
      chk(irq_a, 0, "R10 disabled irq");
      bus_wr(8, 3);

      // R9 counter write masks next tick; R8 clear action
      bus_wr(6, 8'h12);
      wr16(0, 7);
      pulse(1);
      bus_rd(8, v, "R9 model");
      chk(v, 0, "R9 masked match");
      chk(wave_b, 1, "R9 wave untouched");
      wr16(0, 6);
      pulse(2);
      bus_rd(8, v, "R9 model");
      chk(v, 2, "R7 match after mask");
      chk(wave_b, 0, "R8 clear");
      bus_wr(8, 3);

      // R6 clear on A
      bus_wr(6, 8'h13);
      wr16(0, 0);
      pulse(6);
      bus_rd(0, v, "R6 model");
      chk(v, 0, "R6 cleared at match");
      bus_rd(8, v, "R6 model");
      chk(v, 1, "R6 flag A only");
      pulse(1);
      bus_rd(0, v, "R6 model");
      chk(v, 1, "R6 restart");
      bus_wr(8, 7);

      // R11 force: action without flag or counter clear
      w = wave_a;
      wr16(0, 5);
      bus_wr(7, 1);
      chk(wave_a, w ^ 1, "R11 force toggles");
      bus_rd(8, v, "R11 model");
      chk(v, 0, "R11 no flag");
      bus_rd(0, v, "R11 model");
      chk(v, 5, "R11 no counter clear");
      bus_wr(7, 2);
      chk(wave_b, 0, "R11 force B clear");

      // R12 read-as-zero bits
      bus_rd(7, v, "R12 model");
      chk(v, 0, "R12 force reads zero");
      bus_wr(6, 8'hFF);
      bus_rd(6, v, "R12 model");
      chk(v, 8'h1F, "R12 reserved zero");
      bus_wr(6, 8'hE0);
      bus_rd(6, v, "R12 model");
      chk(v, 0, "R12 reserved only");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule